// File: doc/BRIEF.md
# Programmable Real-Time Tick Clock

This peripheral keeps a free-running count of 100 microsecond ticks and gives the processor a periodic interrupt request. The processor controls it through single-cycle I/O commands. Each command has an opcode class, a 4-bit function code and a 6-bit device code. The clock answers only when the device code matches its own address, which is octal 40 by default. Software can start the count, stop it, and read it. Software can never load it: the count starts at zero after reset and only moves forward.

A prescaler divides the system clock down to the 100 microsecond tick. Its ratio is a parameter, so a test can use a short tick. The interrupt does not come from a compare register. It comes from the carry out of the low eight bits of the count, so it fires once every 256 ticks, which is 25.6 ms at the nominal rate.

The request stays asserted until an acknowledge pulse clears it. The control path is a two-state machine:
- **STOPPED** is the reset state. The transition **START** leads from STOPPED to RUNNING.
- **RUNNING** is left through the transition **HALT**, back to STOPPED.

Top module: `rtclk_periph`

## Requirements
- R1: After reset the count is 0, the clock is stopped, and `irq`, `rd_valid`, `skip_out` and `rd_data` are all 0.
- R2: A strobed control-pulse command starts the clock (transition START, STOPPED to RUNNING) when all three of these hold: `cmd_class` is 2'b01, `cmd_func` is 4'h0, and `cmd_dev` is `DEV_CODE`.
- R3: While running, the count rises by exactly one every `TICK_CYCLES` clock cycles. The first increment lands `TICK_CYCLES` edges after the edge that sampled the start command.
- R4: A strobed control-pulse command with `cmd_func` 4'h8 to `DEV_CODE` stops the clock (transition HALT). While stopped, the count does not change.
- R5: While stopped, the prescaler is held cleared. A restart therefore always waits a full `TICK_CYCLES` before its first increment, whatever phase the prescaler had when the clock was stopped.
- R6: A strobed input command (`cmd_class` 2'b10) with `cmd_func` 4'h8 to `DEV_CODE` places the count on `rd_data` one cycle later. In that same cycle `rd_valid` and the skip indication `skip_out` are both high, for one cycle.
- R7: Every other command has no effect on the clock state, on the count and on the read outputs. This covers any other device code, any other function code, the skip class (2'b11), the no-op class (2'b00), and any command presented without `cmd_strobe`.
- R8: `irq` rises on the edge where the count steps from a value whose low `CARRY_BIT` bits are all ones, which gives one request every 2^`CARRY_BIT` ticks.
- R9: Once set, `irq` stays high until `irq_ack` is sampled high. It is low in the cycle after the acknowledge.
- R10: If a carry and an acknowledge occur on the same edge, `irq` stays set.
- R11: The count is `CNT_W` bits wide (16 by default) and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_strobe | input | 1 | One-cycle command valid |
| cmd_class | input | 2 | 00 none, 01 control pulse, 10 input, 11 skip |
| cmd_func | input | 4 | Function code |
| cmd_dev | input | 6 | Device code |
| irq_ack | input | 1 | Interrupt acknowledge / clear |
| rd_data | output | CNT_W | Count returned by a read command |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| skip_out | output | 1 | Ready/skip indication to the processor |
| irq | output | 1 | Periodic interrupt request |

## Verification
Commands are registered on the edge that samples them. A state change takes effect from that edge, and a read result is visible in the cycle just after it. The count steps on every edge that lies a whole multiple of `TICK_CYCLES` after a start. `irq` changes on the carry edge, or on the edge after an acknowledge.

The bench keeps an absolute edge counter and schedules every command and acknowledge for a computed edge. It then samples at the falling edge that follows, so each expected count is a quotient of edge distances. Stops are placed exactly on and one edge before a tick boundary, which separates the count-bearing edge from its neighbours.

// File: rtl/rtclk_pkg.sv
package rtclk_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_PULSE = 2'b01,
        CLS_INPUT = 2'b10,
        CLS_SKIP  = 2'b11
    } cmd_class_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    localparam logic [3:0] FN_START = 4'h0;
    localparam logic [3:0] FN_STOP  = 4'h8;
    localparam logic [3:0] FN_READ  = 4'h8;

endpackage

// File: rtl/rtclk_decode.sv
module rtclk_decode
    import rtclk_pkg::*;
#(
    parameter logic [5:0] DEV_CODE = 6'o40
) (
    input  logic       strobe,
    input  logic [1:0] cls,
    input  logic [3:0] func,
    input  logic [5:0] dev,
    output logic       do_start,
    output logic       do_stop,
    output logic       do_read
);
    logic hit;

    always_comb begin
        hit      = strobe && (dev == DEV_CODE);
        do_start = hit && (cls == CLS_PULSE) && (func == FN_START);
        do_stop  = hit && (cls == CLS_PULSE) && (func == FN_STOP);
        do_read  = hit && (cls == CLS_INPUT) && (func == FN_READ);
    end
endmodule

// File: rtl/rtclk_ctrl.sv
module rtclk_ctrl
    import rtclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_start,
    input  logic do_stop,
    output logic running
);
    run_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // next state: START and HALT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (do_start) state_d = ST_RUNNING;
            ST_RUNNING: if (do_stop)  state_d = ST_STOPPED;
            default:                  state_d = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == ST_RUNNING);
    end
endmodule

// File: rtl/rtclk_prescale.sv
module rtclk_prescale #(
    parameter int TICK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
            logic [PW-1:0] pre_q;
            logic          at_last;

            assign at_last = (pre_q == LAST);
            assign tick    = run && at_last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pre_q <= '0;
                else if (!run)    pre_q <= '0;
                else if (at_last) pre_q <= '0;
                else              pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/rtclk_periph.sv
module rtclk_periph
    import rtclk_pkg::*;
#(
    parameter int         TICK_CYCLES = 10000,
    parameter int         CNT_W       = 16,
    parameter int         CARRY_BIT   = 8,
    parameter logic [5:0] DEV_CODE    = 6'o40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_strobe,
    input  logic [1:0]       cmd_class,
    input  logic [3:0]       cmd_func,
    input  logic [5:0]       cmd_dev,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             skip_out,
    output logic             irq
);
    localparam logic [CARRY_BIT-1:0] LOW_FULL = '1;

    logic             do_start, do_stop, do_read;
    logic             run_w, tick_w, carry_w;
    logic [CNT_W-1:0] cnt_q;

    rtclk_decode #(.DEV_CODE(DEV_CODE)) dec_i (
        .strobe   (cmd_strobe),
        .cls      (cmd_class),
        .func     (cmd_func),
        .dev      (cmd_dev),
        .do_start (do_start),
        .do_stop  (do_stop),
        .do_read  (do_read)
    );

    rtclk_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_start (do_start),
        .do_stop  (do_stop),
        .running  (run_w)
    );

    rtclk_prescale #(.TICK_CYCLES(TICK_CYCLES)) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .tick  (tick_w)
    );

    assign carry_w = tick_w && (cnt_q[CARRY_BIT-1:0] == LOW_FULL);

    // tick count, read-only to software, wraps at CNT_W bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_w) cnt_q <= cnt_q + 1'b1;
    end

    // sticky request; a carry wins over a simultaneous acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= carry_w || (irq && !irq_ack);
    end

    // read response, always ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            skip_out <= 1'b0;
        end else begin
            rd_data  <= do_read ? cnt_q : '0;
            rd_valid <= do_read;
            skip_out <= do_read;
        end
    end
endmodule

// File: rtl/rtclk_periph_chk.sv
module rtclk_periph_chk #(
    parameter int         CNT_W     = 16,
    parameter int         CARRY_BIT = 8,
    parameter logic [5:0] DEV_CODE  = 6'o40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe,
    input logic [1:0]       cls,
    input logic [3:0]       func,
    input logic [5:0]       dev,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             ack,
    input logic             rd_valid,
    input logic             skip
);
    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cls == 2'b01 && func == 4'h0 && dev == DEV_CODE) |=> run);

    // R4
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((cnt == $past(cnt)) || (cnt == ($past(cnt) + CNT_W'(1)))));

    // R6
    read_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(strobe && cls == 2'b10 && func == 4'h8 && dev == DEV_CODE));

    // R6
    read_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> skip);

    // R8
    irq_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt[CARRY_BIT-1:0] == '0));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

bind rtclk_periph rtclk_periph_chk #(
    .CNT_W(CNT_W), .CARRY_BIT(CARRY_BIT), .DEV_CODE(DEV_CODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .strobe(cmd_strobe), .cls(cmd_class),
    .func(cmd_func), .dev(cmd_dev), .run(run_w), .cnt(cnt_q), .irq(irq),
    .ack(irq_ack), .rd_valid(rd_valid), .skip(skip_out)
);

// File: tb/rtclk_periph_tb.sv
module rtclk_periph_tb_top;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int W     = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_strobe = 1'b0;
    logic [1:0]   cmd_class = 2'b00;
    logic [3:0]   cmd_func = 4'h0;
    logic [5:0]   cmd_dev = 6'o0;
    logic         irq_ack = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid, skip_out, irq;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    rtclk_periph #(.TICK_CYCLES(N), .CNT_W(W), .CARRY_BIT(8), .DEV_CODE(6'o40)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_class(cmd_class),
        .cmd_func(cmd_func), .cmd_dev(cmd_dev), .irq_ack(irq_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .skip_out(skip_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge; sampled on the next rising edge
    task automatic issue(input logic [1:0] c, input logic [3:0] f, input logic [5:0] d);
        cmd_strobe = 1'b1; cmd_class = c; cmd_func = f; cmd_dev = d;
        @(negedge clk);
        cmd_strobe = 1'b0; cmd_class = 2'b00; cmd_func = 4'h0; cmd_dev = 6'o0;
    endtask

    task automatic goto(input int e);
        while (edge_n < e) @(negedge clk);
    endtask

    task automatic read_cnt(input string req, input int exp);
        issue(2'b10, 4'h8, 6'o40);
        chk({req, " rd_data"}, int'(rd_data), exp);
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " skip_out"}, int'(skip_out), 1);
    endtask

    task automatic ack_at(input int e);
        goto(e - 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 skip_out", int'(skip_out), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        read_cnt("R1 count", 0);

        // R7 sweep of every command that must be ignored
        for (int d = 0; d < 64; d++) begin
            int bad = 0;
            for (int c = 0; c < 4; c++) begin
                for (int f = 0; f < 16; f++) begin
                    if (d == 32 && ((c == 1 && (f == 0 || f == 8)) || (c == 2 && f == 8)))
                        continue;
                    issue(2'(c), 4'(f), 6'(d));
                    if (rd_valid !== 1'b0 || skip_out !== 1'b0) bad++;
                end
            end
            chk($sformatf("R7 ignored dev %0d", d), bad, 0);
        end
        // R7 valid fields without strobe
        cmd_class = 2'b01; cmd_func = 4'h0; cmd_dev = 6'o40;
        @(negedge clk);
        cmd_class = 2'b00; cmd_dev = 6'o0;
        repeat (3 * N) @(negedge clk);
        read_cnt("R7 still stopped", 0);

        // R2 R3 start, five ticks
        issue(2'b01, 4'h0, 6'o40);
        s = edge_n;
        goto(s + 5 * N - 1);
        issue(2'b01, 4'h8, 6'o40);
        read_cnt("R3 five ticks", 5);

        // R5 stop one edge before a tick, twice
        issue(2'b01, 4'h0, 6'o40);
        s = edge_n;
        goto(s + N - 2);
        issue(2'b01, 4'h8, 6'o40);
        read_cnt("R5 stop before tick", 5);
        issue(2'b01, 4'h0, 6'o40);
        s = edge_n;
        goto(s + N - 2);
        issue(2'b01, 4'h8, 6'o40);
        read_cnt("R5 restart full tick", 5);
        issue(2'b01, 4'h0, 6'o40);
        s = edge_n;
        goto(s + N - 1);
        issue(2'b01, 4'h8, 6'o40);
        read_cnt("R5 first tick", 6);

        // R4 frozen while stopped
        repeat (3 * N) @(negedge clk);
        read_cnt("R4 frozen", 6);

        // R8 R9 R10 R11 long run from count 6
        issue(2'b01, 4'h0, 6'o40);
        s = edge_n;
        goto(s + 250 * N - 1);
        chk("R8 irq before carry", int'(irq), 0);
        goto(s + 250 * N);
        chk("R8 irq on carry", int'(irq), 1);
        goto(s + 300 * N);
        chk("R9 irq sticky", int'(irq), 1);
        ack_at(s + 506 * N);
        chk("R10 carry beats ack", int'(irq), 1);
        ack_at(s + 600 * N);
        chk("R9 ack clears", int'(irq), 0);
        goto(s + 762 * N);
        chk("R8 third carry", int'(irq), 1);
        ack_at(s + 800 * N);
        chk("R9 ack clears again", int'(irq), 0);
        goto(s + 1018 * N - 2);
        read_cnt("R6 read while running", 1023);
        @(negedge clk);
        chk("R6 rd_valid one cycle", int'(rd_valid), 0);
        chk("R8 carry at wrap", int'(irq), 1);
        goto(s + 1019 * N - 1);
        issue(2'b01, 4'h8, 6'o40);
        read_cnt("R11 wrapped", 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule